// File: doc/BRIEF.md
# Programmable Clock Divider Bank

This block derives four slower clocks from one fast system clock: a switch clock, a reference clock, a per-tile core clock and an application clock. Each divider is set through a small write-only register port. A divider programmed with value `v` produces a period of `v+1` source cycles. The whole bank runs in the system clock domain. Each divided output is a registered-state level that a clock-enable or clock-gating cell downstream can consume.

The tile divider is gated by a separate control bit. Until that bit is set, the tile divider behaves as if it were programmed to zero, whatever value has been written. The application divider counts either every system clock cycle or the pulses of a second source, which arrive as one-cycle strobes on `sec_tick`. The divider is enabled when its disable bit is cleared. Once enabled, its output takes over a shared output pin that otherwise carries an ordinary port value.

Top module: `clkdiv_bank`

## Requirements
- R1: A divider whose active value is `v >= 1` repeats with a period of `N = v+1` source cycles. Within each period it is high for the first `floor(N/2)` source cycles and low for the rest. A divider whose active value is 0 holds its output high while it is enabled.
- R2: After reset the switch divider value is 0, so `sw_clk_out` stays high.
- R3: After reset the reference divider value is 4, so `ref_clk_out` is high for 2 of every 5 cycles.
- R4: A reference value of 1 gives the fastest reference clock: high 1 cycle, low 1 cycle.
- R5: The tile divider uses the value written at address 2 only while bit 4 of the tile control register (address 3) is set. While that bit is clear, `tile_clk_out` behaves as divide-by-1 and stays high.
- R6: In the application register (address 4), bit 31 selects the count source. When bit 31 is clear, the divider counts every system clock cycle. When bit 31 is set, it counts one step per `sec_tick` pulse.
- R7: Bit 16 of the application register is a disable bit, and it is set after reset. While it is set, `app_clk_out` is low, `pin_is_clk` is 0, and `pin_out` follows `port_drive`.
- R8: While bit 16 is clear, `pin_is_clk` is 1 and `pin_out` equals `app_clk_out` on every cycle.
- R9: A newly written value becomes active only at the terminal count of the running period. The period in progress completes with the old ratio, so no shortened pulse appears.
- R10: Odd ratios are not 50% duty: for example, divide-by-7 is high 3 cycles and low 4 cycles.
- R11: Writes go to address 0 (switch), 1 (reference), 2 (tile value), 3 (tile control) and 4 (application). The value field is bits 15:0. A write is visible in the register after the clock edge that samples `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, the source of every divider |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| sec_tick | input | 1 | One-cycle strobe per edge of the second application source |
| port_drive | input | 1 | Normal port value for the shared pin |
| sw_clk_out | output | 1 | Divided switch clock |
| ref_clk_out | output | 1 | Divided reference clock |
| tile_clk_out | output | 1 | Divided tile clock |
| app_clk_out | output | 1 | Divided application clock |
| pin_out | output | 1 | Shared pin value: application clock or port value |
| pin_is_clk | output | 1 | High while the pin carries the application clock |

## Verification
A register write lands at the first rising edge after `wr_en` is driven. A divider then moves to the new value only after it finishes its current period, which can take up to the old `N` source cycles. For this reason the ratio checks first wait a settle interval longer than any old period. They then count high samples and rising edges over a window that is an exact multiple of the new period, so the result does not depend on phase. The terminal-count test works differently: it aligns to an observed rising edge, writes a new value in that same cycle, and compares the next 15 samples one period at a time. Because all samples are taken on the falling edge, each one sees state settled after the preceding rising edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int DIV_W   = 16;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 32;
    localparam int NUM_DIV = 4;

    localparam int APP_SRC_BIT = 31;
    localparam int APP_OFF_BIT = 16;
    localparam int TILE_GO_BIT = 4;

    localparam int DIV_SW   = 0;
    localparam int DIV_REF  = 1;
    localparam int DIV_TILE = 2;
    localparam int DIV_APP  = 3;

    localparam logic [DIV_W-1:0] REF_RST_VAL = DIV_W'(4);

    typedef enum logic [ADDR_W-1:0] {
        A_SW   = 3'd0,
        A_REF  = 3'd1,
        A_TILE = 3'd2,
        A_TCTL = 3'd3,
        A_APP  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [DIV_W-1:0] sw_div;
        logic [DIV_W-1:0] ref_div;
        logic [DIV_W-1:0] tile_div;
        logic             tile_go;
        logic [DIV_W-1:0] app_div;
        logic             app_sec;
        logic             app_off;
    } cfg_t;

    function automatic logic [DIV_W-1:0] reset_value(input int idx);
        return (idx == DIV_REF) ? REF_RST_VAL : '0;
    endfunction

    // number of high source cycles in one period of a divide-by-(v+1)
    function automatic logic [DIV_W:0] high_span(input logic [DIV_W-1:0] v);
        return ({1'b0, v} + (DIV_W+1)'(1)) >> 1;
    endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg
);
    logic [DIV_W-1:0] wval;
    logic             unused_hi;

    assign wval      = wr_data[DIV_W-1:0];
    assign unused_hi = ^wr_data[APP_SRC_BIT-1:APP_OFF_BIT+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.sw_div   <= reset_value(DIV_SW);
            cfg.ref_div  <= reset_value(DIV_REF);
            cfg.tile_div <= reset_value(DIV_TILE);
            cfg.tile_go  <= 1'b0;
            cfg.app_div  <= reset_value(DIV_APP);
            cfg.app_sec  <= 1'b0;
            cfg.app_off  <= 1'b1;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                A_SW:   cfg.sw_div   <= wval;
                A_REF:  cfg.ref_div  <= wval;
                A_TILE: cfg.tile_div <= wval;
                A_TCTL: cfg.tile_go  <= wr_data[TILE_GO_BIT];
                A_APP: begin
                    cfg.app_div <= wval;
                    cfg.app_sec <= wr_data[APP_SRC_BIT];
                    cfg.app_off <= wr_data[APP_OFF_BIT];
                end
                default: ;
            endcase
        end
    end

    // R11
    ref_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'(A_REF)) |=> cfg.ref_div == $past(wr_data[DIV_W-1:0]));

    // R6
    app_src_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'(A_APP)) |=> cfg.app_sec == $past(wr_data[APP_SRC_BIT]));
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
    import clkdiv_pkg::*;
#(
    parameter int             W       = DIV_W,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         tick,
    input  logic [W-1:0] div_val,
    output logic         lvl
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] act_q;
    logic [W:0]   half;
    logic         term;

    assign term = (cnt_q == act_q);
    assign half = ({1'b0, act_q} + (W+1)'(1)) >> 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= RST_VAL;
        end else if (!en) begin
            cnt_q <= '0;
            act_q <= div_val;
        end else if (tick) begin
            if (term) begin
                cnt_q <= '0;
                act_q <= div_val;
            end else begin
                cnt_q <= cnt_q + W'(1);
            end
        end
    end

    always_comb begin
        lvl = en && ((act_q == '0) || ({1'b0, cnt_q} < half));
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= act_q);

    // R9
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_q) |-> $past(!en || (tick && cnt_q == act_q)));

    // R7
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> cnt_q == '0);
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sec_tick,
    input  logic              port_drive,
    output logic              sw_clk_out,
    output logic              ref_clk_out,
    output logic              tile_clk_out,
    output logic              app_clk_out,
    output logic              pin_out,
    output logic              pin_is_clk
);
    cfg_t             cfg;
    logic [DIV_W-1:0] dv  [NUM_DIV];
    logic             den [NUM_DIV];
    logic             dtk [NUM_DIV];
    logic             dlv [NUM_DIV];
    logic             app_on;

    clkdiv_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    assign app_on = !cfg.app_off;

    always_comb begin
        dv[DIV_SW]    = cfg.sw_div;
        dv[DIV_REF]   = cfg.ref_div;
        dv[DIV_TILE]  = cfg.tile_go ? cfg.tile_div : '0;
        dv[DIV_APP]   = cfg.app_div;
        den[DIV_SW]   = 1'b1;
        den[DIV_REF]  = 1'b1;
        den[DIV_TILE] = 1'b1;
        den[DIV_APP]  = app_on;
        dtk[DIV_SW]   = 1'b1;
        dtk[DIV_REF]  = 1'b1;
        dtk[DIV_TILE] = 1'b1;
        dtk[DIV_APP]  = cfg.app_sec ? sec_tick : 1'b1;
    end

    for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
        clkdiv_core #(
            .W       (DIV_W),
            .RST_VAL (reset_value(i))
        ) u_div (
            .clk     (clk),
            .rst     (rst),
            .en      (den[i]),
            .tick    (dtk[i]),
            .div_val (dv[i]),
            .lvl     (dlv[i])
        );
    end

    assign sw_clk_out   = dlv[DIV_SW];
    assign ref_clk_out  = dlv[DIV_REF];
    assign tile_clk_out = dlv[DIV_TILE];
    assign app_clk_out  = dlv[DIV_APP];
    assign pin_out      = app_on ? dlv[DIV_APP] : port_drive;
    assign pin_is_clk   = app_on;
endmodule

// File: tb/tb_clkdiv_bank.sv
module tb_clkdiv_bank;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic        sec_tick;
    logic        port_drive;
    logic        sw_clk_out, ref_clk_out, tile_clk_out, app_clk_out;
    logic        pin_out, pin_is_clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    clkdiv_bank dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sec_tick(sec_tick), .port_drive(port_drive),
        .sw_clk_out(sw_clk_out), .ref_clk_out(ref_clk_out), .tile_clk_out(tile_clk_out),
        .app_clk_out(app_clk_out), .pin_out(pin_out), .pin_is_clk(pin_is_clk)
    );

    always #5 clk = ~clk;

    initial begin
        int ph = 0;
        sec_tick = 1'b0;
        forever begin
            @(negedge clk);
            ph = (ph + 1) % 3;
            sec_tick = (ph == 0);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int s);
        case (s)
            0: return sw_clk_out;
            1: return ref_clk_out;
            2: return tile_clk_out;
            default: return app_clk_out;
        endcase
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int s, input int m, output int hi, output int rises, output int mism);
        logic prev;
        @(negedge clk);
        prev = pick(s);
        hi = 0; rises = 0; mism = 0;
        for (int i = 0; i < m; i++) begin
            @(negedge clk);
            if (pick(s)) hi++;
            if (pick(s) && !prev) rises++;
            if (pin_out !== app_clk_out) mism++;
            prev = pick(s);
        end
    endtask

    task automatic t_reset();
        int hi, r, mm;
        measure(0, 8, hi, r, mm);
        chk(hi == 8, "R2 switch held high after reset", hi, 8);
        measure(1, 20, hi, r, mm);
        chk(hi == 8, "R3 reference high count div5", hi, 8);
        chk(r == 4, "R3 reference rises div5", r, 4);
        measure(3, 8, hi, r, mm);
        chk(hi == 0, "R7 app low while disabled", hi, 0);
        chk(pin_is_clk == 1'b0, "R7 pin_is_clk after reset", int'(pin_is_clk), 0);
        port_drive = 1'b1; settle(1);
        chk(pin_out == 1'b1, "R7 pin follows port (1)", int'(pin_out), 1);
        port_drive = 1'b0; settle(1);
        chk(pin_out == 1'b0, "R7 pin follows port (0)", int'(pin_out), 0);
    endtask

    task automatic t_terminal_load();
        logic prev, cur;
        int h1, h2;
        prev = 1'b1; cur = ref_clk_out;
        while (!(prev == 1'b0 && cur == 1'b1)) begin
            @(negedge clk);
            prev = cur; cur = ref_clk_out;
        end
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'd9;
        h1 = 1; h2 = 0;
        for (int i = 1; i < 15; i++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (ref_clk_out) begin
                if (i < 5) h1++; else h2++;
            end
        end
        chk(h1 == 2, "R9 old period completes with old ratio", h1, 2);
        chk(h2 == 5, "R9 new ratio from next period", h2, 5);
    endtask

    task automatic t_ratios();
        int hi, r, mm;
        measure(1, 40, hi, r, mm);
        chk(hi == 20, "R1 reference div10 high count", hi, 20);
        wr(3'd1, 32'd1); settle(30);
        measure(1, 8, hi, r, mm);
        chk(hi == 4 && r == 4, "R4 reference div2", hi * 10 + r, 44);
        wr(3'd1, 32'd6); settle(30);
        measure(1, 28, hi, r, mm);
        chk(hi == 12, "R10 div7 high is floor(7/2)", hi, 12);
        chk(r == 4, "R10 div7 rises", r, 4);
        wr(3'd0, 32'd7); settle(30);
        measure(0, 32, hi, r, mm);
        chk(hi == 16 && r == 4, "R11 switch address 0 div8", hi * 10 + r, 164);
    endtask

    task automatic t_tile();
        int hi, r, mm;
        wr(3'd2, 32'd3); settle(30);
        measure(2, 16, hi, r, mm);
        chk(hi == 16, "R5 tile value ignored without control bit", hi, 16);
        wr(3'd3, 32'h10); settle(30);
        measure(2, 16, hi, r, mm);
        chk(hi == 8 && r == 4, "R5 tile div4 after control bit 4", hi * 10 + r, 84);
    endtask

    task automatic t_app();
        int hi, r, mm;
        wr(3'd4, 32'h0000_0002); settle(30);
        chk(pin_is_clk == 1'b1, "R8 pin_is_clk when enabled", int'(pin_is_clk), 1);
        measure(3, 12, hi, r, mm);
        chk(hi == 4 && r == 4, "R6 system source div3", hi * 10 + r, 44);
        chk(mm == 0, "R8 pin carries app clock", mm, 0);
        wr(3'd4, 32'h8000_0002); settle(60);
        measure(3, 36, hi, r, mm);
        chk(hi == 12 && r == 4, "R6 second source div3 per tick", hi * 10 + r, 124);
        chk(mm == 0, "R8 pin carries app clock (second source)", mm, 0);
        wr(3'd4, 32'h0001_0000); settle(3);
        measure(3, 12, hi, r, mm);
        chk(hi == 0, "R7 app low after disable", hi, 0);
        port_drive = 1'b1; settle(1);
        chk(pin_out == 1'b1 && pin_is_clk == 1'b0, "R7 pin back to port", int'(pin_out), 1);
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; port_drive = 1'b0;
        settle(4);
        rst = 1'b0;
        settle(20);
        t_reset();
        t_terminal_load();
        t_ratios();
        t_tile();
        t_app();
        report();
    end

    initial begin
        #(100000 * 10);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end
endmodule